// File: doc/BRIEF.md
# Serial Key Mode-Entry Detector

This block sits on the target side of a serial programming port. It decides whether the device may enter its program/verify mode. It watches three pins: a programming-enable level, a serial data line and a serial clock. All three are brought into the block's own clock domain through two-flop synchronizers.

Entry takes three steps in a fixed order. First, the enable is applied briefly and released. Second, after a quiet gap, a 32-bit key is shifted in most significant bit first, one bit on each rising serial clock edge. Third, the enable is applied again and held. Only the key 32'h4D434850 arms the detector. Once the enable is held after a matching key, the block raises `mode_active` and `io_hiz`. `io_hiz` asks the pad ring to float every unused I/O.

A `data_valid` strobe rises only after a further settling interval. Serial traffic before that point must be discarded by the command logic downstream. Dropping the enable ends the mode, and the block goes back to idle.

Top module: `serial_key_entry`

## Requirements
- R1: After a short enable pulse, a quiet gap, the correct 32-bit key, and the enable raised and held, `mode_active` goes high and stays high while the enable is held.
- R2: Only the key value 32'h4D434850 grants entry. A word that differs in any bit leaves `mode_active` low when the enable is held afterwards.
- R3: Key bits are taken most significant bit first: the first rising serial clock edge supplies bit 31. The correct key sent least significant bit first does not grant entry.
- R4: Serial clock edges during the first PRE_GAP cycles after the synchronized enable falls are ignored. A stray bit clocked in that window does not stop a correct key that follows from granting entry.
- R5: `data_valid` is low when `mode_active` first rises. It goes high once the mode has lasted POST_GAP further cycles, and it is never high without `mode_active`.
- R6: `io_hiz` is high exactly when `mode_active` is high.
- R7: Removing the enable while in mode drops `mode_active`, `io_hiz` and `data_valid`, and the block returns to idle.
- R8: Raising the enable before all 32 key bits have arrived abandons the attempt. Holding the enable then does not grant entry.
- R9: After a wrong key, a correct key sent without a fresh enable pulse does not grant entry. A new pulse followed by the correct key does.
- R10: While reset is asserted, and on leaving it, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Programming-enable level, high when applied (asynchronous) |
| ser_clk | input | 1 | Serial clock; key bits are taken on its rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data line carrying the key (asynchronous) |
| mode_active | output | 1 | High while program/verify mode is active |
| io_hiz | output | 1 | Request to place all unused I/O in high impedance |
| data_valid | output | 1 | High once serial data in mode may be trusted |

## Verification
The bench tries the entry sequence with these patterns:
- the exact key, which separates a working comparator from a stuck-off one;
- the key with its lowest bit flipped, and the key bit-reversed, which reveal a comparator that checks too little and a shifter that runs in the wrong direction;
- a stray clock edge inside the post-pulse gap, which shows whether early bits leak into the shift register;
- an enable that returns halfway through the key, and a retry without a fresh pulse, which show whether the sequencer really insists on the three steps in order.

A behavioural reference model runs beside the design. On every cycle it predicts the three outputs, so the exact cycle of entry, of `data_valid` and of exit is checked as well as the final outcome.

// File: rtl/skd_pkg.sv
// Package: shared types for the serial key mode-entry detector.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package skd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for the first enable pulse
        ST_PULSE,   // enable applied, waiting for its release
        ST_GAP,     // enable released, waiting out the pre-key delay
        ST_KEY,     // shifting key bits
        ST_ARMED,   // key matched, waiting for the enable to return
        ST_ACTIVE   // program/verify mode
    } skd_state_t;

endpackage

// File: rtl/skd_sync.sv
// Module: two-flop synchronizer, one chain per input bit.
// Assumes: inputs are level signals that change slower than clk; reset clears to 0.
module skd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_chain
        logic meta;
        // Two flops per bit to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= 1'b0;
                q[i] <= 1'b0;
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end

endmodule

// File: rtl/skd_timer.sv
// Module: saturating interval timer.
// Counts cycles while clear is low, holds at LIMIT and flags done there.
// Assumes: clear is high for at least one cycle before each interval starts.
module skd_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);

    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count up to LIMIT and stay there until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);

    // Once reached, the interval stays complete until cleared (R5, R4).
    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);

endmodule

// File: rtl/skd_keyshift.sv
// Module: key shift register, MSB first.
// Shifts one bit per shift strobe and flags the last bit of the word.
// Assumes: clear is held whenever the sequencer is not collecting key bits.
module skd_keyshift #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_in,
    output logic             last,
    output logic [KEY_W-1:0] word_next
);

    localparam int CW = $clog2(KEY_W);

    logic [KEY_W-2:0] sh;
    logic [CW-1:0]    cnt;

    // Collect bits so that the first one received ends up in the top position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (shift) begin
            sh  <= word_next[KEY_W-2:0];
            cnt <= cnt + 1'b1;
        end
    end

    assign last      = (cnt == CW'(KEY_W - 1));
    assign word_next = {sh, bit_in};

    // Each accepted bit advances the bit position by exactly one (R3).
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear && !last) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/serial_key_entry.sv
// Module: serial key mode-entry detector (top).
// Walks the pulse / key / re-hold sequence and drives the mode outputs.
// Assumes: prog_en, ser_clk, ser_dat are asynchronous and slower than clk;
// each serial clock phase lasts at least two clk cycles.
module serial_key_entry #(
    parameter int          KEY_W    = 32,
    parameter logic [31:0] KEY      = 32'h4D434850,
    parameter int          PRE_GAP  = 8,
    parameter int          POST_GAP = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic mode_active,
    output logic io_hiz,
    output logic data_valid
);

    import skd_pkg::*;

    localparam logic [KEY_W-1:0] KEY_VAL = KEY_W'(KEY);

    logic [2:0]       sync_q;
    logic             en_s, clk_s, dat_s, clk_prev, clk_rise;
    logic             pre_done, post_done, key_last;
    logic [KEY_W-1:0] key_word;
    skd_state_t       state, state_nx;

    skd_sync #(.W(3)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({prog_en, ser_clk, ser_dat}),
        .q     (sync_q)
    );

    assign {en_s, clk_s, dat_s} = sync_q;

    // Remember the previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_s;
    end

    assign clk_rise = clk_s && !clk_prev;

    skd_timer #(.LIMIT(PRE_GAP)) i_pre_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_GAP),
        .done  (pre_done)
    );

    skd_timer #(.LIMIT(POST_GAP)) i_post_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_ACTIVE),
        .done  (post_done)
    );

    skd_keyshift #(.KEY_W(KEY_W)) i_keyshift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state != ST_KEY),
        .shift     ((state == ST_KEY) && clk_rise),
        .bit_in    (dat_s),
        .last      (key_last),
        .word_next (key_word)
    );

    // Next-state decision for the entry sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en_s) state_nx = ST_PULSE;
            ST_PULSE:  if (!en_s) state_nx = ST_GAP;
            ST_GAP: begin
                if (en_s)          state_nx = ST_IDLE;
                else if (pre_done) state_nx = ST_KEY;
            end
            ST_KEY: begin
                if (en_s) state_nx = ST_IDLE;
                else if (clk_rise && key_last)
                    state_nx = (key_word == KEY_VAL) ? ST_ARMED : ST_IDLE;
            end
            ST_ARMED:  if (en_s) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (!en_s) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign mode_active = (state == ST_ACTIVE);
    assign io_hiz      = (state == ST_ACTIVE);
    assign data_valid  = (state == ST_ACTIVE) && post_done;

    // Mode is only entered while the synchronized enable is applied (R1).
    p_entry_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> $past(en_s));

    // Valid data never without mode, and never on the first mode cycle (R5).
    p_valid_in_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> mode_active);
    p_valid_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> !data_valid);

    // Hi-Z request tracks the mode (R6).
    p_hiz_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_hiz == mode_active);

    // Losing the enable ends the mode on the next cycle (R7).
    p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && !en_s) |=> !mode_active);

endmodule

// File: tb/test_serial_key_entry.sv
module test_serial_key_entry;

    localparam int          PRE  = 8;
    localparam int          POST = 12;
    localparam logic [31:0] KEYV = 32'h4D434850;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic mode_active, io_hiz, data_valid;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    serial_key_entry #(.PRE_GAP(PRE), .POST_GAP(POST)) i_serial_key_entry (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .mode_active(mode_active), .io_hiz(io_hiz),
        .data_valid(data_valid)
    );

    // Behavioural reference model: phases as integers, delays as counters.
    // phase: 0 idle, 1 pulse, 2 gap, 3 key, 4 armed, 5 in mode
    int  m_phase = 0;
    int  m_pre = 0, m_post = 0, m_nbits = 0;
    bit [31:0] m_word = '0;
    bit  m_en[2], m_sc[2], m_dt[2];
    bit  m_scprev = 0;

    always @(posedge clk) begin
        bit en_s, sc_s, dt_s, rise;
        int nph;
        if (!rst_n) begin
            m_phase = 0; m_pre = 0; m_post = 0; m_nbits = 0; m_word = '0;
            m_en = '{0, 0}; m_sc = '{0, 0}; m_dt = '{0, 0}; m_scprev = 0;
        end else begin
            en_s = m_en[1]; sc_s = m_sc[1]; dt_s = m_dt[1];
            rise = sc_s && !m_scprev;
            nph = m_phase;
            case (m_phase)
                0: if (en_s) nph = 1;
                1: if (!en_s) nph = 2;
                2: if (en_s) nph = 0; else if (m_pre >= PRE) nph = 3;
                3: if (en_s) nph = 0;
                   else if (rise && m_nbits == 31)
                       nph = ({m_word[30:0], dt_s} == KEYV) ? 4 : 0;
                4: if (en_s) nph = 5;
                5: if (!en_s) nph = 0;
                default: nph = 0;
            endcase
            if (m_phase != 2) m_pre = 0; else if (m_pre < PRE) m_pre++;
            if (m_phase != 5) m_post = 0; else if (m_post < POST) m_post++;
            if (m_phase != 3) begin m_nbits = 0; m_word = '0; end
            else if (rise) begin m_word = {m_word[30:0], dt_s}; m_nbits++; end
            m_phase = nph;
            m_scprev = sc_s;
            m_en[1] = m_en[0]; m_en[0] = prog_en;
            m_sc[1] = m_sc[0]; m_sc[0] = ser_clk;
            m_dt[1] = m_dt[0]; m_dt[0] = ser_dat;
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check("R1", "model mode_active", mode_active, m_phase == 5);
            check("R6", "model io_hiz", io_hiz, m_phase == 5);
            check("R5", "model data_valid", data_valid, (m_phase == 5) && (m_post >= POST));
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        prog_en = 1'b1; wait_n(4); prog_en = 1'b0;
    endtask

    task automatic send_bit(bit b);
        ser_dat = b; ser_clk = 1'b0; wait_n(3);
        ser_clk = 1'b1; wait_n(3);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(logic [31:0] w, int nbits);
        for (int i = 31; i > 31 - nbits; i--) send_bit(w[i]);
    endtask

    task automatic hold_en(int n);
        wait_n(4); prog_en = 1'b1; wait_n(n);
    endtask

    task automatic leave();
        prog_en = 1'b0; wait_n(8);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rev;
        for (int i = 0; i < 32; i++) rev[i] = KEYV[31 - i];
        wait_n(3);
        // R10: outputs low during reset
        check("R10", "reset mode_active", mode_active, 1'b0);
        check("R10", "reset io_hiz", io_hiz, 1'b0);
        check("R10", "reset data_valid", data_valid, 1'b0);
        rst_n = 1'b1;
        wait_n(2);
        check("R10", "after reset mode_active", mode_active, 1'b0);

        // R1/R5/R6/R7: good entry, settle, exit
        pulse(); wait_n(PRE + 6);
        send_word(KEYV, 32);
        hold_en(5);
        check("R1", "mode after good key", mode_active, 1'b1);
        check("R6", "hiz in mode", io_hiz, 1'b1);
        check("R5", "data_valid early", data_valid, 1'b0);
        wait_n(POST + 3);
        check("R5", "data_valid settled", data_valid, 1'b1);
        leave();
        check("R7", "mode after exit", mode_active, 1'b0);
        check("R7", "hiz after exit", io_hiz, 1'b0);
        check("R7", "valid after exit", data_valid, 1'b0);

        // R4: stray edge inside the gap is ignored
        pulse(); wait_n(1);
        ser_dat = 1'b1; ser_clk = 1'b1; wait_n(2); ser_clk = 1'b0;
        wait_n(PRE + 6);
        send_word(KEYV, 32);
        hold_en(5);
        check("R4", "mode despite early edge", mode_active, 1'b1);
        leave();

        // R2: one bit wrong
        pulse(); wait_n(PRE + 6);
        send_word(KEYV ^ 32'h1, 32);
        hold_en(20);
        check("R2", "mode after wrong key", mode_active, 1'b0);
        leave();

        // R3: bit-reversed key
        pulse(); wait_n(PRE + 6);
        send_word(rev, 32);
        hold_en(20);
        check("R3", "mode after LSB-first key", mode_active, 1'b0);
        leave();

        // R9: wrong key, then good key without pulse, then with pulse
        pulse(); wait_n(PRE + 6);
        send_word(~KEYV, 32);
        wait_n(4);
        send_word(KEYV, 32);
        hold_en(20);
        check("R9", "mode without fresh pulse", mode_active, 1'b0);
        prog_en = 1'b0; wait_n(PRE + 8);
        send_word(KEYV, 32);
        hold_en(5);
        check("R9", "mode after fresh pulse", mode_active, 1'b1);
        leave();

        // R8: enable returns halfway through the key
        pulse(); wait_n(PRE + 6);
        send_word(KEYV, 16);
        hold_en(30);
        check("R8", "mode after aborted key", mode_active, 1'b0);
        leave();

        done_flag = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule